// File: doc/BRIEF.md
# Vectored Interrupt Priority Controller

This block keeps three per-vector bit arrays for up to 256 interrupt vectors. The pending array records requests. The in-service array records interrupts the CPU has accepted and not yet retired. The trigger-kind array records whether the most recent request for each vector was level or edge. Every cycle the block finds the highest set vector in the pending and in-service arrays. It combines the in-service class with a task priority register to form a processor priority, and it raises a registered interrupt line toward the CPU when a pending vector beats that priority. A vector's class is its upper nibble.

The CPU takes an interrupt with a one-cycle acknowledge handshake. The reply is one of three things: the winning vector, which moves from pending to in-service; the programmable spurious vector, when the top request is masked by priority; or "nothing". An end-of-interrupt command retires the highest in-service vector. For level-triggered vectors it can emit a broadcast pulse that carries the retired vector to the interrupt sources. A control register, a task-priority port and a combinational read port give access to the register state. The block does no destination routing and has no timers.

Top module: `vec_irq_ctrl`

## Requirements
- R1: An accepted acknowledge returns the highest-numbered pending vector, regardless of the order in which requests arrived.
- R2: Processor priority is the task priority when the task class (bits 7:4) is greater than or equal to the class of the highest in-service vector. Otherwise it is that class followed by four zero bits. An empty in-service array counts as class 0.
- R3: With control bit 8 (enable) clear, or with no request pending, the interrupt line stays low and an acknowledge reports status 0 (none) with vector 0.
- R4: When the processor priority is nonzero and the top pending class is less than or equal to the priority class, the request is blocked. The interrupt line is low, the pending array is unchanged, and an acknowledge reports status 2 with control bits 7:0 as the vector.
- R5: An accepted acknowledge reports status 1 in the cycle after the request. In the same update it clears the vector's pending bit and sets its in-service bit.
- R6: A request sets the vector's pending bit. It sets the vector's trigger bit when the level input is 1 and clears it when the level input is 0.
- R7: End-of-interrupt clears the highest in-service bit. It pulses the broadcast output with that vector, one cycle later, only when the vector's trigger bit is set and control bit 12 is clear. With an empty in-service array it does nothing.
- R8: A control write keeps data bits 8:0 and also bit 12 when DIRECTED_EOI_EN is 1. All other bits read as zero.
- R9: The 8-bit task write stores the data as given. The 4-bit task write stores the nibble in bits 7:4 with zero below, and it wins when both writes occur in the same cycle.
- R10: The interrupt line is a registered level that follows the state of the previous cycle. It rises one cycle after a change makes a pending vector deliverable.
- R11: A request and an acknowledge in the same cycle both take effect. The acknowledge decides from the pending array as it stood before that request.
- R12: Reset clears the pending, in-service and trigger arrays and the task priority, and sets the control register to 0x0FF.
- R13: A request whose vector is NUM_VEC or above is dropped.
- R14: Read address map (rd_addr): 0x00 is task priority, 0x01 is processor priority, 0x02 is control. 0x08+w reads in-service word w, 0x10+w reads trigger word w, and 0x18+w reads pending word w; word w holds vectors 32w to 32w+31, with the lowest vector in bit 0. Words at or beyond NUM_VEC/32, and all other addresses, read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Interrupt request strobe |
| req_vector | input | 8 | Requested vector |
| req_level | input | 1 | 1 = level trigger, 0 = edge trigger |
| ack_req | input | 1 | CPU acknowledge strobe |
| eoi_cmd | input | 1 | End-of-interrupt command |
| tpr_wr | input | 1 | Full task-priority write strobe |
| tpr_data | input | 8 | Full task-priority value |
| crt_wr | input | 1 | 4-bit task-priority write strobe |
| crt_data | input | 4 | Task-priority class value |
| svr_wr | input | 1 | Control register write strobe |
| svr_data | input | 16 | Control register write data |
| rd_addr | input | 6 | Read address |
| rd_data | output | 32 | Read data (combinational) |
| irq_out | output | 1 | Interrupt level to the CPU |
| ack_done | output | 1 | Acknowledge reply valid |
| ack_status | output | 2 | 0 none, 1 vector, 2 spurious |
| ack_vector | output | 8 | Acknowledge reply vector |
| eoi_bcast_valid | output | 1 | End-of-interrupt broadcast pulse |
| eoi_bcast_vector | output | 8 | Vector retired by the broadcast |

## Verification
The bench builds the block with NUM_VEC = 128, DIRECTED_EOI_EN = 1 and the two-level finder. The smaller vector space makes an out-of-range request (vector 0x90) and a read of a missing register word (0x1C) real cases. With the directed-EOI bit kept, a level-triggered end-of-interrupt can be suppressed through the control register. Class ties, blocking by in-service priority, blocking by task priority and a request that lands in the same cycle as an acknowledge are each driven at the ports.

// File: rtl/vic_pkg.sv
package vic_pkg;

   typedef enum logic [1:0] {
      ACK_NONE = 2'd0,
      ACK_VEC  = 2'd1,
      ACK_SPUR = 2'd2
   } ack_stat_e;

   localparam int WORD_W       = 32;
   localparam int SVR_EN_BIT   = 8;
   localparam int SVR_DEOI_BIT = 12;

   localparam logic [2:0] RGRP_CTL = 3'd0;
   localparam logic [2:0] RGRP_ISR = 3'd1;
   localparam logic [2:0] RGRP_TMR = 3'd2;
   localparam logic [2:0] RGRP_IRR = 3'd3;

   localparam logic [2:0] RSEL_TPR = 3'd0;
   localparam logic [2:0] RSEL_PPR = 3'd1;
   localparam logic [2:0] RSEL_SVR = 3'd2;

endpackage

// File: rtl/vic_top_finder.sv
module vic_top_finder #(
   parameter int N         = 256,
   parameter bit TWO_LEVEL = 1'b1,
   localparam int IW       = $clog2(N)
) (
   input  logic [N-1:0]  bits_i,
   output logic          found_o,
   output logic [IW-1:0] idx_o
);

   if (TWO_LEVEL) begin : g_two_level
      localparam int NW = N / vic_pkg::WORD_W;
      logic [NW-1:0] wfound;
      logic [4:0]    widx [NW];

      for (genvar w = 0; w < NW; w++) begin : g_word
         logic [31:0] slice;
         logic        f;
         logic [4:0]  ix;
         assign slice = bits_i[w*32 +: 32];
         always_comb begin
            f  = |slice;
            ix = '0;
            for (int b = 0; b < 32; b++) begin
               if (slice[b]) ix = b[4:0];
            end
         end
         assign wfound[w] = f;
         assign widx[w]   = ix;
      end

      always_comb begin
         found_o = |wfound;
         idx_o   = '0;
         for (int w = 0; w < NW; w++) begin
            if (wfound[w]) idx_o = IW'(w * 32) | IW'(widx[w]);
         end
      end
   end else begin : g_flat
      always_comb begin
         found_o = |bits_i;
         idx_o   = '0;
         for (int i = 0; i < N; i++) begin
            if (bits_i[i]) idx_o = i[IW-1:0];
         end
      end
   end

endmodule

// File: rtl/vic_vec_regs.sv
module vic_vec_regs #(
   parameter int N   = 256,
   localparam int IW = $clog2(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          set_i,
   input  logic [IW-1:0] set_idx_i,
   input  logic          set_level_i,
   input  logic          take_i,
   input  logic [IW-1:0] take_idx_i,
   input  logic          retire_i,
   input  logic [IW-1:0] retire_idx_i,
   output logic [N-1:0]  irr_o,
   output logic [N-1:0]  isr_o,
   output logic [N-1:0]  tmr_o
);

   localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

   logic [N-1:0] set_m, take_m, ret_m;

   assign set_m  = set_i    ? (ONE << set_idx_i)    : '0;
   assign take_m = take_i   ? (ONE << take_idx_i)   : '0;
   assign ret_m  = retire_i ? (ONE << retire_idx_i) : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irr_o <= '0;
         isr_o <= '0;
         tmr_o <= '0;
      end else begin
         irr_o <= (irr_o & ~take_m) | set_m;
         isr_o <= (isr_o & ~ret_m) | take_m;
         tmr_o <= set_level_i ? (tmr_o | set_m) : (tmr_o & ~set_m);
      end
   end

   AST_SET_MARKS_IRR: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> irr_o[$past(set_idx_i)]); // R6

   AST_RETIRE_CLEARS_ISR: assert property (@(posedge clk) disable iff (!rst_n)
      (retire_i && !take_i) |=> !isr_o[$past(retire_idx_i)]); // R7

endmodule

// File: rtl/vic_prio_calc.sv
module vic_prio_calc (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [7:0] tpr_i,
   input  logic       sw_en_i,
   input  logic       isr_found_i,
   input  logic [7:0] isr_vec_i,
   input  logic       irr_found_i,
   input  logic [7:0] irr_vec_i,
   output logic [7:0] ppr_o,
   output logic       deliver_o,
   output logic       blocked_o
);

   logic [3:0] isr_cls;
   logic       masked;

   always_comb begin
      isr_cls   = isr_found_i ? isr_vec_i[7:4] : 4'h0;
      ppr_o     = (tpr_i[7:4] >= isr_cls) ? tpr_i : {isr_cls, 4'h0};
      masked    = (ppr_o != 8'h00) && (irr_vec_i[7:4] <= ppr_o[7:4]);
      deliver_o = sw_en_i && irr_found_i && !masked;
      blocked_o = sw_en_i && irr_found_i && masked;
   end

   AST_PPR_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
      ppr_o >= tpr_i); // R2

   AST_DELIVER_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(deliver_o && blocked_o)); // R4

endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl #(
   parameter int NUM_VEC         = 256,
   parameter bit DIRECTED_EOI_EN = 1'b0,
   parameter bit TWO_LEVEL_FIND  = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        req_valid,
   input  logic [7:0]  req_vector,
   input  logic        req_level,
   input  logic        ack_req,
   input  logic        eoi_cmd,
   input  logic        tpr_wr,
   input  logic [7:0]  tpr_data,
   input  logic        crt_wr,
   input  logic [3:0]  crt_data,
   input  logic        svr_wr,
   input  logic [15:0] svr_data,
   input  logic [5:0]  rd_addr,
   output logic [31:0] rd_data,
   output logic        irq_out,
   output logic        ack_done,
   output logic [1:0]  ack_status,
   output logic [7:0]  ack_vector,
   output logic        eoi_bcast_valid,
   output logic [7:0]  eoi_bcast_vector
);
   import vic_pkg::*;

   localparam int IW        = $clog2(NUM_VEC);
   localparam int NUM_WORDS = NUM_VEC / WORD_W;
   localparam int WSEL      = $clog2(NUM_WORDS);
   localparam logic [15:0] SVR_MASK = DIRECTED_EOI_EN ? 16'h11FF : 16'h01FF;
   localparam logic [15:0] SVR_RST  = 16'h00FF;

   if (NUM_VEC != 64 && NUM_VEC != 128 && NUM_VEC != 256) begin : g_bad_num_vec
      $error("vec_irq_ctrl: NUM_VEC must be 64, 128 or 256");
   end

   logic [NUM_VEC-1:0] irr_q, isr_q, tmr_q;
   logic [7:0]         tpr_q;
   logic [15:0]        svr_q;
   logic               sw_en, deoi;

   logic               irr_found, isr_found;
   logic [IW-1:0]      irr_idx, isr_idx;
   logic [7:0]         irr_v, isr_v, ppr;
   logic               deliver, blocked;

   logic               req_ok, ack_take, eoi_take, bcast;

   logic               irq_q, ack_done_q, eoi_bc_q;
   ack_stat_e          ack_stat_q;
   logic [7:0]         ack_vec_q, eoi_vec_q;

   assign sw_en = svr_q[SVR_EN_BIT];

   if (DIRECTED_EOI_EN) begin : g_deoi
      assign deoi = svr_q[SVR_DEOI_BIT];
   end else begin : g_no_deoi
      assign deoi = 1'b0;
   end

   vic_top_finder #(.N(NUM_VEC), .TWO_LEVEL(TWO_LEVEL_FIND)) u_irr_find (
      .bits_i (irr_q),
      .found_o(irr_found),
      .idx_o  (irr_idx)
   );

   vic_top_finder #(.N(NUM_VEC), .TWO_LEVEL(TWO_LEVEL_FIND)) u_isr_find (
      .bits_i (isr_q),
      .found_o(isr_found),
      .idx_o  (isr_idx)
   );

   assign irr_v = 8'(irr_idx);
   assign isr_v = 8'(isr_idx);

   vic_prio_calc u_prio (
      .clk        (clk),
      .rst_n      (rst_n),
      .tpr_i      (tpr_q),
      .sw_en_i    (sw_en),
      .isr_found_i(isr_found),
      .isr_vec_i  (isr_v),
      .irr_found_i(irr_found),
      .irr_vec_i  (irr_v),
      .ppr_o      (ppr),
      .deliver_o  (deliver),
      .blocked_o  (blocked)
   );

   assign req_ok   = req_valid && (32'(req_vector) < NUM_VEC);
   assign ack_take = ack_req && deliver;
   assign eoi_take = eoi_cmd && isr_found;
   assign bcast    = eoi_take && tmr_q[isr_idx] && !deoi;

   vic_vec_regs #(.N(NUM_VEC)) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .set_i       (req_ok),
      .set_idx_i   (req_vector[IW-1:0]),
      .set_level_i (req_level),
      .take_i      (ack_take),
      .take_idx_i  (irr_idx),
      .retire_i    (eoi_take),
      .retire_idx_i(isr_idx),
      .irr_o       (irr_q),
      .isr_o       (isr_q),
      .tmr_o       (tmr_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tpr_q <= '0;
         svr_q <= SVR_RST;
      end else begin
         if (crt_wr) tpr_q <= {crt_data, 4'h0};
         else if (tpr_wr) tpr_q <= tpr_data;
         if (svr_wr) svr_q <= svr_data & SVR_MASK;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_q      <= 1'b0;
         ack_done_q <= 1'b0;
         ack_stat_q <= ACK_NONE;
         ack_vec_q  <= '0;
         eoi_bc_q   <= 1'b0;
         eoi_vec_q  <= '0;
      end else begin
         irq_q      <= deliver;
         ack_done_q <= ack_req;
         if (ack_req && deliver) begin
            ack_stat_q <= ACK_VEC;
            ack_vec_q  <= irr_v;
         end else if (ack_req && blocked) begin
            ack_stat_q <= ACK_SPUR;
            ack_vec_q  <= svr_q[7:0];
         end else begin
            ack_stat_q <= ACK_NONE;
            ack_vec_q  <= '0;
         end
         eoi_bc_q  <= bcast;
         eoi_vec_q <= bcast ? isr_v : '0;
      end
   end

   logic [31:0] isr_w [NUM_WORDS];
   logic [31:0] tmr_w [NUM_WORDS];
   logic [31:0] irr_w [NUM_WORDS];

   for (genvar w = 0; w < NUM_WORDS; w++) begin : g_rd_word
      assign isr_w[w] = isr_q[w*WORD_W +: WORD_W];
      assign tmr_w[w] = tmr_q[w*WORD_W +: WORD_W];
      assign irr_w[w] = irr_q[w*WORD_W +: WORD_W];
   end

   logic [2:0] rd_low;
   logic       rd_word_ok;

   always_comb begin
      rd_low     = rd_addr[2:0];
      rd_word_ok = 32'(rd_low) < NUM_WORDS;
      rd_data    = '0;
      case (rd_addr[5:3])
         RGRP_CTL: begin
            case (rd_low)
               RSEL_TPR: rd_data = {24'd0, tpr_q};
               RSEL_PPR: rd_data = {24'd0, ppr};
               RSEL_SVR: rd_data = {16'd0, svr_q};
               default:  rd_data = '0;
            endcase
         end
         RGRP_ISR: if (rd_word_ok) rd_data = isr_w[rd_low[WSEL-1:0]];
         RGRP_TMR: if (rd_word_ok) rd_data = tmr_w[rd_low[WSEL-1:0]];
         RGRP_IRR: if (rd_word_ok) rd_data = irr_w[rd_low[WSEL-1:0]];
         default:  rd_data = '0;
      endcase
   end

   assign irq_out          = irq_q;
   assign ack_done         = ack_done_q;
   assign ack_status       = ack_stat_q;
   assign ack_vector       = ack_vec_q;
   assign eoi_bcast_valid  = eoi_bc_q;
   assign eoi_bcast_vector = eoi_vec_q;

   AST_ACK_SETS_ISR: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_done_q && ack_stat_q == ACK_VEC) |-> isr_q[ack_vec_q[IW-1:0]]); // R5

   AST_IDLE_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (!svr_q[SVR_EN_BIT] || irr_q == '0) |=> !irq_q); // R3

   AST_BCAST_ON_EOI: assert property (@(posedge clk) disable iff (!rst_n)
      eoi_bc_q |-> $past(eoi_cmd)); // R7

   AST_OOR_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && 32'(req_vector) >= NUM_VEC && !ack_req) |=> $stable(irr_q)); // R13

endmodule

// File: tb/vec_irq_ctrl_bench.sv
`timescale 1ns/1ps
module vec_irq_ctrl_bench;

   localparam logic [3:0] OP_RD  = 4'd1;
   localparam logic [3:0] OP_REQ = 4'd2;
   localparam logic [3:0] OP_ACK = 4'd3;
   localparam logic [3:0] OP_EOI = 4'd4;
   localparam logic [3:0] OP_TPR = 4'd5;
   localparam logic [3:0] OP_CRT = 4'd6;
   localparam logic [3:0] OP_SVR = 4'd7;
   localparam logic [3:0] OP_IRQ = 4'd8;

   localparam int N_TBL = 57;
   // {op, requirement, argument, expected}
   localparam logic [55:0] TBL [N_TBL] = '{
      {OP_RD,  4'd12, 16'h0002, 32'h0000_00FF}, // R12 control reset
      {OP_RD,  4'd12, 16'h001A, 32'h0000_0000}, // R12 pending empty
      {OP_REQ, 4'd6,  16'h0045, 32'h0},         // R6 edge 0x45
      {OP_IRQ, 4'd3,  16'h0000, 32'h0000_0000}, // R3 disabled
      {OP_ACK, 4'd3,  16'h0000, 32'h0000_0000}, // R3 none
      {OP_SVR, 4'd8,  16'hE1F0, 32'h0},         // R8 enable
      {OP_RD,  4'd8,  16'h0002, 32'h0000_01F0}, // R8 masked
      {OP_IRQ, 4'd10, 16'h0000, 32'h0000_0001}, // R10
      {OP_REQ, 4'd6,  16'h0162, 32'h0},         // R6 level 0x62
      {OP_RD,  4'd6,  16'h001B, 32'h0000_0004}, // R6 pending word 3
      {OP_RD,  4'd6,  16'h0013, 32'h0000_0004}, // R6 trigger word 3
      {OP_RD,  4'd6,  16'h0012, 32'h0000_0000}, // R6 edge clears trigger
      {OP_ACK, 4'd1,  16'h0000, 32'h0000_0162}, // R1 highest wins
      {OP_RD,  4'd5,  16'h000B, 32'h0000_0004}, // R5 in service
      {OP_RD,  4'd5,  16'h001B, 32'h0000_0000}, // R5 pending cleared
      {OP_RD,  4'd2,  16'h0001, 32'h0000_0060}, // R2 isr class
      {OP_ACK, 4'd4,  16'h0000, 32'h0000_02F0}, // R4 spurious
      {OP_RD,  4'd4,  16'h001A, 32'h0000_0020}, // R4 pending kept
      {OP_IRQ, 4'd4,  16'h0000, 32'h0000_0000}, // R4 line low
      {OP_TPR, 4'd9,  16'h0075, 32'h0},         // R9
      {OP_RD,  4'd2,  16'h0001, 32'h0000_0075}, // R2 tpr wins
      {OP_CRT, 4'd9,  16'h0003, 32'h0},         // R9
      {OP_RD,  4'd9,  16'h0000, 32'h0000_0030}, // R9 shifted
      {OP_RD,  4'd2,  16'h0001, 32'h0000_0060}, // R2
      {OP_IRQ, 4'd4,  16'h0000, 32'h0000_0000}, // R4
      {OP_EOI, 4'd7,  16'h0000, 32'h0000_0162}, // R7 level broadcast
      {OP_IRQ, 4'd10, 16'h0000, 32'h0000_0001}, // R10
      {OP_ACK, 4'd1,  16'h0000, 32'h0000_0145}, // R1
      {OP_EOI, 4'd7,  16'h0000, 32'h0000_0000}, // R7 edge silent
      {OP_EOI, 4'd7,  16'h0000, 32'h0000_0000}, // R7 empty
      {OP_RD,  4'd7,  16'h000A, 32'h0000_0000}, // R7
      {OP_REQ, 4'd6,  16'h0150, 32'h0},         // R6 level 0x50
      {OP_SVR, 4'd8,  16'h11F0, 32'h0},         // R8 directed bit
      {OP_RD,  4'd8,  16'h0002, 32'h0000_11F0}, // R8
      {OP_ACK, 4'd5,  16'h0000, 32'h0000_0150}, // R5
      {OP_EOI, 4'd7,  16'h0000, 32'h0000_0000}, // R7 directed suppresses
      {OP_RD,  4'd7,  16'h000A, 32'h0000_0000}, // R7 cleared anyway
      {OP_REQ, 4'd13, 16'h0090, 32'h0},         // R13 out of range
      {OP_ACK, 4'd13, 16'h0000, 32'h0000_0000}, // R13 nothing pending
      {OP_RD,  4'd14, 16'h001C, 32'h0000_0000}, // R14 missing word
      {OP_CRT, 4'd9,  16'h0000, 32'h0},         // R9
      {OP_REQ, 4'd6,  16'h0020, 32'h0},         // R6
      {OP_REQ, 4'd6,  16'h002F, 32'h0},         // R6
      {OP_ACK, 4'd1,  16'h0000, 32'h0000_012F}, // R1 same class tie
      {OP_RD,  4'd2,  16'h0001, 32'h0000_0020}, // R2
      {OP_ACK, 4'd4,  16'h0000, 32'h0000_02F0}, // R4 equal class
      {OP_EOI, 4'd7,  16'h0000, 32'h0000_0000}, // R7
      {OP_ACK, 4'd1,  16'h0000, 32'h0000_0120}, // R1
      {OP_EOI, 4'd7,  16'h0000, 32'h0000_0000}, // R7
      {OP_SVR, 4'd3,  16'h00F0, 32'h0},         // R3 disable
      {OP_REQ, 4'd6,  16'h0033, 32'h0},         // R6
      {OP_IRQ, 4'd3,  16'h0000, 32'h0000_0000}, // R3
      {OP_ACK, 4'd3,  16'h0000, 32'h0000_0000}, // R3
      {OP_SVR, 4'd8,  16'h01F0, 32'h0},         // R8
      {OP_IRQ, 4'd10, 16'h0000, 32'h0000_0001}, // R10
      {OP_ACK, 4'd5,  16'h0000, 32'h0000_0133}, // R5
      {OP_EOI, 4'd7,  16'h0000, 32'h0000_0000}  // R7
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [7:0]  req_vector = '0;
   logic        req_level = 1'b0;
   logic        ack_req = 1'b0;
   logic        eoi_cmd = 1'b0;
   logic        tpr_wr = 1'b0;
   logic [7:0]  tpr_data = '0;
   logic        crt_wr = 1'b0;
   logic [3:0]  crt_data = '0;
   logic        svr_wr = 1'b0;
   logic [15:0] svr_data = '0;
   logic [5:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic        irq_out, ack_done, eoi_bcast_valid;
   logic [1:0]  ack_status;
   logic [7:0]  ack_vector, eoi_bcast_vector;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   vec_irq_ctrl #(.NUM_VEC(128), .DIRECTED_EOI_EN(1'b1), .TWO_LEVEL_FIND(1'b1)) u_vec_irq_ctrl (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_vector(req_vector), .req_level(req_level),
      .ack_req(ack_req), .eoi_cmd(eoi_cmd),
      .tpr_wr(tpr_wr), .tpr_data(tpr_data), .crt_wr(crt_wr), .crt_data(crt_data),
      .svr_wr(svr_wr), .svr_data(svr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .irq_out(irq_out), .ack_done(ack_done), .ack_status(ack_status), .ack_vector(ack_vector),
      .eoi_bcast_valid(eoi_bcast_valid), .eoi_bcast_vector(eoi_bcast_vector)
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic clear_in();
      req_valid = 1'b0; ack_req = 1'b0; eoi_cmd = 1'b0;
      tpr_wr = 1'b0; crt_wr = 1'b0; svr_wr = 1'b0;
   endtask

   function automatic logic [31:0] ack_word();
      return ack_done ? {22'd0, ack_status, ack_vector} : 32'hFFFF_FFFF;
   endfunction

   // Called at a falling edge; drives, waits one cycle, checks, releases.
   task automatic do_op(input logic [3:0] op, input logic [15:0] arg,
                        input logic [31:0] exp, input string tag);
      case (op)
         OP_RD:  rd_addr = arg[5:0];
         OP_REQ: begin req_valid = 1'b1; req_vector = arg[7:0]; req_level = arg[8]; end
         OP_ACK: ack_req = 1'b1;
         OP_EOI: eoi_cmd = 1'b1;
         OP_TPR: begin tpr_wr = 1'b1; tpr_data = arg[7:0]; end
         OP_CRT: begin crt_wr = 1'b1; crt_data = arg[3:0]; end
         OP_SVR: begin svr_wr = 1'b1; svr_data = arg; end
         default: ;
      endcase
      @(negedge clk);
      case (op)
         OP_RD:  chk(tag, rd_data, exp);
         OP_ACK: chk(tag, ack_word(), exp);
         OP_EOI: chk(tag, {23'd0, eoi_bcast_valid, eoi_bcast_vector}, exp);
         OP_IRQ: chk(tag, {31'd0, irq_out}, exp);
         default: ;
      endcase
      clear_in();
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < N_TBL; i++) begin
         do_op(TBL[i][55:52], TBL[i][47:32], TBL[i][31:0],
               $sformatf("R%0d step %0d", TBL[i][51:48], i));
      end

      // R11: request and acknowledge in the same cycle
      do_op(OP_REQ, 16'h0030, 32'h0, "R11 setup");
      req_valid = 1'b1; req_vector = 8'h70; req_level = 1'b0; ack_req = 1'b1;
      @(negedge clk);
      chk("R11 ack uses old pending", ack_word(), 32'h0000_0130);
      clear_in();
      do_op(OP_RD,  16'h001B, 32'h0001_0000, "R11 new request kept");
      do_op(OP_RD,  16'h0019, 32'h0000_0000, "R11 old vector left pending");
      do_op(OP_RD,  16'h0009, 32'h0001_0000, "R11 old vector in service");
      do_op(OP_ACK, 16'h0000, 32'h0000_0170, "R11 later ack");
      do_op(OP_EOI, 16'h0000, 32'h0000_0000, "R11 retire");
      do_op(OP_EOI, 16'h0000, 32'h0000_0000, "R11 retire");

      // R9: both task writes in one cycle
      tpr_wr = 1'b1; tpr_data = 8'h55; crt_wr = 1'b1; crt_data = 4'h2;
      @(negedge clk);
      clear_in();
      do_op(OP_RD,  16'h0000, 32'h0000_0020, "R9 nibble path wins");

      // R12: reset mid-run
      do_op(OP_REQ, 16'h0141, 32'h0, "R12 setup");
      do_op(OP_TPR, 16'h0080, 32'h0, "R12 setup");
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      do_op(OP_RD,  16'h0000, 32'h0000_0000, "R12 task cleared");
      do_op(OP_RD,  16'h0002, 32'h0000_00FF, "R12 control reset");
      do_op(OP_RD,  16'h001A, 32'h0000_0000, "R12 pending cleared");
      do_op(OP_RD,  16'h0012, 32'h0000_0000, "R12 trigger cleared");
      do_op(OP_IRQ, 16'h0000, 32'h0000_0000, "R12 line low");

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

endmodule